// File: doc/BRIEF.md
# RAM-Backed Programmable Serial Delay Line

This block delays a serial bit stream by a programmable number of bit times. The bits are held in a small RAM whose words are two bits wide. A 4-bit address counter walks the RAM once per pass. Each address is visited for two bit times: the low half on the first and the high half on the second. On each visit the stored bit is read out and the incoming bit is written into the same place.

A comparator watches the counter against the upper four bits of a 5-bit length code. When they match on the high half, the pass ends and the counter is preloaded for the next pass. In even mode the preload value is zero. In odd mode it is one, and after the match one extra bit time is spent in a separate one-bit side register while the counter holds. Even mode gives delays of 2 to 32 bits and odd mode gives 3 to 31 bits.

All activity is paced by a bit-time strobe, which acts as a clock enable. The length code and the mode are sampled only at the end of a pass.

Top module: `ram_delay_line`

## Requirements
- R1: In even mode (`odd_mode`=0) with H = `len_code[4:1]`, after each strobe `dout` equals the `din` value sampled 2*(H+1) strobes earlier. This covers delays 2 to 32.
- R2: In odd mode (`odd_mode`=1) with H = `len_code[4:1]` in 1..15, after each strobe `dout` equals the `din` value sampled 2*H+1 strobes earlier. The longest odd delay is 31; H=0 is not a legal odd setting.
- R3: At the end of a pass the address counter is preloaded with 1 when the newly sampled mode is odd and with 0 when it is even. Address 0 is therefore never used in odd mode.
- R4: In odd mode the side register takes exactly one strobe after each counter match. During that strobe `dout` takes the side register's old value, the side register captures `din`, and the address counter holds.
- R5: On a clock where `bit_stb` is low, nothing changes: not `dout`, not the counter, not the half select, not the side register, whatever `din`, `len_code` or `odd_mode` do.
- R6: A synchronous active-low reset clears `dout`, the counter, the half select, the side register and the latched setting (H=0, even). The first pass after reset is therefore two strobes long, and it samples the inputs at its end. RAM contents are not cleared.
- R7: `len_code` and `odd_mode` take effect only at the strobe that ends the current pass. A change that is withdrawn before that strobe has no effect on the delay.
- R8: `len_code[0]` has no effect; codes that differ only in that bit give the same delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | Bit-time enable; one bit moves per high cycle |
| din | input | 1 | Serial data in |
| len_code | input | 5 | Length code; bits [4:1] set the match address |
| odd_mode | input | 1 | 1 selects odd lengths (preload one, side register used) |
| dout | output | 1 | Delayed serial data, registered |

## Verification
A table of even and odd settings runs a pseudo-random bit stream through the block and compares every output bit against a reference shift history. The settings include the shortest and longest lengths and code pairs that differ only in bit 0, which separates a correct two-bit-per-address pass from off-by-one preload or compare faults. A directed run with odd H=1 after reset drives ones, so the output is zero only where the freshly cleared side register is read. This pins the first-pass length and the single side-register slot. Further runs raise a setting change mid-pass and withdraw it, make a permanent change without reset, and hold the strobe low while toggling every input, which shows when the setting is sampled and that the strobe gates all state.

// File: rtl/vdl_pkg.sv
// Package: shared constants and types for the RAM-backed delay line.
// Assumes two data bits per RAM word; the half select is one bit wide.
package vdl_pkg;
    localparam int BITS_PER_WORD = 2;
    localparam int HALF_W        = 1;

    typedef enum logic [HALF_W-1:0] {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/vdl_ram.sv
// Module: vdl_ram
// Small RAM holding BITS_PER_WORD data bits per address, one lane per bit.
// Assumes read-before-write: rd_bit shows the old bit at (addr, half) in
// the same cycle as a write to that spot. No reset on the storage.
module vdl_ram
    import vdl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  half_e             half,
    input  logic              wr_bit,
    output logic              rd_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BITS_PER_WORD-1:0] lane_rd;

    for (genvar g = 0; g < BITS_PER_WORD; g++) begin : g_lane
        logic store [DEPTH];

        // Write the incoming bit into this lane when its half is selected.
        always_ff @(posedge clk) begin
            if (wr_en && (half == half_e'(g))) begin
                store[addr] <= wr_bit;
            end
        end

        assign lane_rd[g] = store[addr];
    end

    // Select the lane that belongs to the current half.
    always_comb begin
        rd_bit = lane_rd[half];
    end
endmodule

// File: rtl/vdl_seq.sv
// Module: vdl_seq
// Pass sequencer: address counter, half select, comparator and side-slot
// flag. The match value and mode are latched only at the end of a pass.
// Assumes stb is a one-cycle clock enable per bit time. Reset is
// synchronous and active low.
module vdl_seq
    import vdl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [ADDR_W-1:0] match_in,
    input  logic              odd_in,
    output logic [ADDR_W-1:0] addr,
    output half_e             half,
    output logic              side_slot
);
    logic [ADDR_W-1:0] match_q;
    logic              odd_q;
    logic              pass_end;

    // Comparator: the pass ends on the high half of the matching address.
    always_comb begin
        pass_end = (addr == match_q) && (half == HALF_HI) && !side_slot;
    end

    // Step through halves and addresses; on a match latch the new setting,
    // preload the counter and, if the finished pass was odd, open the side slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            half      <= HALF_LO;
            side_slot <= 1'b0;
            match_q   <= '0;
            odd_q     <= 1'b0;
        end else if (stb) begin
            if (side_slot) begin
                side_slot <= 1'b0;
            end else if (half == HALF_LO) begin
                half <= HALF_HI;
            end else begin
                half <= HALF_LO;
                if (pass_end) begin
                    match_q   <= match_in;
                    odd_q     <= odd_in;
                    addr      <= odd_in ? ADDR_W'(1) : '0;
                    side_slot <= odd_q;
                end else begin
                    addr <= addr + 1'b1;
                end
            end
        end
    end

    // R4: the side slot lasts a single strobe.
    a_r4_side_slot_single: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && side_slot) |=> !side_slot);

    // R4: the counter holds through the side slot.
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && side_slot) |=> (addr == $past(addr)));

    // R3: odd preload is one.
    a_r3_odd_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && pass_end && odd_in) |=> (addr == ADDR_W'(1)));

    // R3: even preload is zero.
    a_r3_even_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && pass_end && !odd_in) |=> (addr == '0));

    // R5: no strobe, no movement.
    a_r5_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(addr) && $stable(half) && $stable(side_slot)));

    // R7: the latched setting changes only at a pass end.
    a_r7_setting_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && pass_end) |=> ($stable(match_q) && $stable(odd_q)));
endmodule

// File: rtl/vdl_side_reg.sv
// Module: vdl_side_reg
// One-bit side register that supplies the extra bit time in odd mode.
// Assumes slot is high for exactly the strobe it is used in.
module vdl_side_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic slot,
    input  logic din,
    output logic q
);
    // Capture the serial input during the side slot only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (stb && slot) begin
            q <= din;
        end
    end

    // R4: the side register takes din in its slot.
    a_r4_side_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && slot) |=> (q == $past(din)));

    // R5: the side register holds when not in its slot.
    a_r5_side_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && slot) |=> $stable(q));
endmodule

// File: rtl/ram_delay_line.sv
// Module: ram_delay_line
// Programmable serial delay line. A RAM with two bits per word is walked by
// a counter whose pass length is set by the upper bits of len_code; odd mode
// adds a one-bit side slot per pass. dout is registered and updates on each
// strobe. Assumes odd mode is used with len_code[4:1] >= 1.
module ram_delay_line
    import vdl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             din,
    input  logic [LEN_W-1:0] len_code,
    input  logic             odd_mode,
    output logic             dout
);
    logic [ADDR_W-1:0] addr;
    half_e             half;
    logic              side_slot;
    logic              ram_rd;
    logic              side_q;
    logic              ram_we;
    logic              len_lsb_unused;

    // Bit 0 of the length code does not take part in the compare.
    assign len_lsb_unused = len_code[0];

    // Write the RAM on every strobe that is not a side slot.
    assign ram_we = bit_stb && !side_slot && rst_n;

    vdl_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (bit_stb),
        .match_in  (len_code[LEN_W-1:1]),
        .odd_in    (odd_mode),
        .addr      (addr),
        .half      (half),
        .side_slot (side_slot)
    );

    vdl_ram #(.ADDR_W(ADDR_W)) ram_i (
        .clk    (clk),
        .wr_en  (ram_we),
        .addr   (addr),
        .half   (half),
        .wr_bit (din),
        .rd_bit (ram_rd)
    );

    vdl_side_reg side_i (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (bit_stb),
        .slot  (side_slot),
        .din   (din),
        .q     (side_q)
    );

    // Output register: take the side bit in its slot, else the RAM bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (bit_stb) begin
            dout <= side_slot ? side_q : ram_rd;
        end
    end

    // R5: the output holds without a strobe.
    a_r5_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(dout));

    // R4: in the side slot the output takes the side register's old bit.
    a_r4_dout_from_side: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && side_slot) |=> (dout == $past(side_q)));
endmodule

// File: tb/ram_delay_line_tb_top.sv
// Bench for ram_delay_line: a table of settings with expected delays, walked
// by one loop, then directed tests for reset, strobe gating and setting changes.
module ram_delay_line_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       din = 1'b0;
    logic [4:0] len_code = 5'd0;
    logic       odd_mode = 1'b0;
    logic       dout;

    int n_cmp = 0;
    int n_bad = 0;
    int k = 0;
    logic hist [0:1023];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    ram_delay_line dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .din      (din),
        .len_code (len_code),
        .odd_mode (odd_mode),
        .dout     (dout)
    );

    // Each entry: {odd_mode, len_code[4:0], expected delay[5:0]}.
    localparam int NVEC = 14;
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 5'd0,  6'd2},  {1'b0, 5'd1,  6'd2},
        {1'b0, 5'd2,  6'd4},  {1'b0, 5'd7,  6'd8},
        {1'b0, 5'd13, 6'd14}, {1'b0, 5'd16, 6'd18},
        {1'b0, 5'd30, 6'd32}, {1'b0, 5'd31, 6'd32},
        {1'b1, 5'd2,  6'd3},  {1'b1, 5'd3,  6'd3},
        {1'b1, 5'd9,  6'd9},  {1'b1, 5'd21, 6'd21},
        {1'b1, 5'd30, 6'd31}, {1'b1, 5'd31, 6'd31}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at strobe %0d: dout=%b expected %b", req, k, act, exp);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_stb = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 reset clears dout", dout, 1'b0);
        rst_n = 1'b1;
        k = 0;
    endtask

    task automatic strobe(input logic d);
        @(negedge clk);
        din = d;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        k++;
        hist[k] = d;
        @(negedge clk);
    endtask

    initial begin
        #(100_000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] dly;
        logic held;

        // Table walk: R1 even lengths, R2 odd lengths, R8 bit 0 ignored, R3 preload.
        for (int v = 0; v < NVEC; v++) begin
            odd_mode = VEC[v][11];
            len_code = VEC[v][10:6];
            dly = VEC[v][5:0];
            do_reset();
            for (int s = 0; s < 140; s++) begin
                strobe(next_bit());
                if (k >= 70) begin
                    if (odd_mode) check("R2/R3 odd delay", dout, hist[k - int'(dly)]);
                    else          check("R1/R8 even delay", dout, hist[k - int'(dly)]);
                end
            end
        end

        // R6/R4: first pass after reset is two strobes; cleared side bit appears at strobe 5.
        odd_mode = 1'b1;
        len_code = 5'd2;
        do_reset();
        for (int s = 1; s <= 8; s++) begin
            strobe(1'b1);
            if (k == 5) check("R6 side register cleared", dout, 1'b0);
            if (k == 8) check("R4 side slot delay", dout, 1'b1);
        end

        // R7/R5: even H=5 (delay 12); passes end at strobes 2, 14, 26, 38, 50.
        odd_mode = 1'b0;
        len_code = 5'd10;
        do_reset();
        for (int s = 1; s <= 80; s++) begin
            if (s == 41) begin
                len_code = 5'd31;
                odd_mode = 1'b1;
            end
            if (s == 49) begin
                len_code = 5'd10;
                odd_mode = 1'b0;
            end
            strobe(next_bit());
            if (k >= 30) check("R7 withdrawn change ignored", dout, hist[k - 12]);
            if (k == 60) begin
                held = dout;
                for (int c = 0; c < 8; c++) begin
                    @(negedge clk);
                    din = ~din;
                    len_code = len_code ^ 5'h1F;
                    odd_mode = ~odd_mode;
                    check("R5 no strobe no change", dout, held);
                end
                len_code = 5'd10;
                odd_mode = 1'b0;
            end
        end

        // R7/R2: a lasting change without reset takes effect; odd 31 after settling.
        len_code = 5'd31;
        odd_mode = 1'b1;
        for (int s = 81; s <= 200; s++) begin
            strobe(next_bit());
            if (k >= 150) check("R7 change applied, R2 delay 31", dout, hist[k - 31]);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule